// File: doc/BRIEF.md
# Double-Buffered Full-Duplex Synchronous Serial Port

This block is a synchronous serial port that sends and receives at the same time. The transmit side and the receive side are independent. Each has its own externally supplied bit clock, its own frame-sync input and its own shift register. Software reaches the port through a small register file that it reads and writes like any other data location. The register file holds a transmit data register, a receive data register and a control register whose single mode bit selects 8-bit or 16-bit words.

Both directions are double-buffered. On the transmit side, software may write the next word into the transmit register while the previous word is still shifting out. On the receive side, a finished word stays in the receive register while the next word shifts in. Each direction crosses into the system clock domain through a toggle handshake that passes through a two-flop synchronizer. Each produces a one-cycle interrupt request. The transmit request fires when the transmit register is copied into its shift register. The receive request fires when a completed word lands in the receive register.

Top module: `sport_duplex`

## Requirements
- R1: After reset, the transmit register (address 0) and the receive register (address 1) read 0. The control register (address 2) reads 1, which selects word mode. `tx_sd` is low and both interrupt outputs are low.
- R2: A write to address 0 updates the transmit register and a write to address 2 updates the mode. Bit 0 of address 2 selects the mode: 1 means 16-bit and 0 means 8-bit. Both registers read back what was written.
- R3: In 16-bit mode, when `tx_fsync` is sampled high on a falling edge of `tx_bclk`, the transmit register is loaded into the shift register. The 16 bits are then driven most significant first, one on each following rising edge.
- R4: In 8-bit mode, only bits 7..0 of the transmit register are sent, bit 7 first. `tx_sd` is low whenever no word is being sent.
- R5: `irq_tx_empty` pulses for exactly one system clock each time a word is copied into the transmit shift register. A word written during shifting does not disturb the word on the line and is sent in the next frame.
- R6: In 16-bit mode, when `rx_fsync` is sampled high on a falling edge of `rx_bclk`, the next 16 falling edges sample `rx_sd`, most significant bit first. The finished word then appears at address 1, together with a one-cycle pulse on `irq_rx_full`.
- R7: In 8-bit mode, the receiver samples 8 bits and places them in bits 7..0 of the receive register, with bits 15..8 cleared.
- R8: A frame-sync sampled on the same falling edge as a frame's last bit starts the next frame with no idle bit, in both directions.
- R9: Transmit and receive run at the same time on unrelated bit clocks without affecting each other.
- R10: The receive register holds its word until the next word completes. Reading it does not clear it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset for all domains |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 transmit, 2 control) |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address (0 transmit, 1 receive, 2 control) |
| rd_data | output | 16 | Read data, combinational from rd_addr |
| tx_bclk | input | 1 | Transmit bit clock |
| tx_fsync | input | 1 | Transmit frame sync |
| tx_sd | output | 1 | Transmit serial data |
| rx_bclk | input | 1 | Receive bit clock |
| rx_fsync | input | 1 | Receive frame sync |
| rx_sd | input | 1 | Receive serial data |
| irq_tx_empty | output | 1 | Transmit-register-empty pulse |
| irq_rx_full | output | 1 | Receive-register-full pulse |

## Verification
The bench builds the port with a 16-bit word, an 8-bit byte and two synchronizer stages. The 16/8 split exercises both the padded path and the unpadded path in each shift register. Two stages keep the handshake latency to about three system cycles, which is well inside one bit period. That lets the bench rewrite the transmit register in the middle of a frame and run back-to-back frames with no gap. The transmit bit clock (40 ns) and the receive bit clock (56 ns) are unrelated, so the full-duplex run overlaps frames at shifting phase offsets.

// File: rtl/sport_pkg.sv
package sport_pkg;
   // Register map of the port (two address bits)
   localparam int SP_ADDR_W = 2;
   typedef enum logic [SP_ADDR_W-1:0] {
      SP_REG_TX  = 2'd0,
      SP_REG_RX  = 2'd1,
      SP_REG_CTL = 2'd2
   } sp_reg_e;
endpackage

// File: rtl/sport_tgl_sync.sv
// Toggle-to-pulse crossing: multi-stage synchronizer followed by an edge detector.
module sport_tgl_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tgl_in,
   output logic pulse
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("sport_tgl_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-1:0], tgl_in};
   end

   assign pulse = chain[STAGES] ^ chain[STAGES-1];

   // R5 / R6: toggles arrive many system cycles apart, so a pulse never lasts two cycles
   a_r5_pulse_single : assert property (@(posedge clk) disable iff (!rst_n)
      pulse |=> !pulse);
endmodule

// File: rtl/sport_tx_lane.sv
// Transmit shift path, clocked entirely by the external transmit bit clock.
module sport_tx_lane #(
   parameter int WORD_W = 16,
   parameter int BYTE_W = 8
) (
   input  logic              bclk,
   input  logic              rst_n,
   input  logic              fsync,
   input  logic              word_mode,
   input  logic [WORD_W-1:0] hold_word,
   output logic              sd,
   output logic              load_tgl
);
   localparam int CNT_W = $clog2(WORD_W + 1);
   localparam int PAD_W = WORD_W - BYTE_W;

   generate
      if (BYTE_W < 2 || PAD_W < 1) begin : g_bad_widths
         $error("sport_tx_lane: need 2 <= BYTE_W < WORD_W");
      end
   endgenerate

   logic [WORD_W-1:0] shreg;
   logic [CNT_W-1:0]  bits_left;
   logic              busy;
   logic [WORD_W-1:0] load_val;
   logic [CNT_W-1:0]  load_len;

   // Byte mode left-aligns the low byte so the MSB-first shifter needs no second path.
   always_comb begin
      if (word_mode) begin
         load_val = hold_word;
         load_len = CNT_W'(WORD_W);
      end else begin
         load_val = {hold_word[BYTE_W-1:0], {PAD_W{1'b0}}};
         load_len = CNT_W'(BYTE_W);
      end
   end

   // Falling edge: frame-sync sampling, loading and shifting
   always_ff @(negedge bclk or negedge rst_n) begin
      if (!rst_n) begin
         shreg     <= '0;
         bits_left <= '0;
         busy      <= 1'b0;
         load_tgl  <= 1'b0;
      end else if (fsync) begin
         shreg     <= load_val;
         bits_left <= load_len;
         busy      <= 1'b1;
         load_tgl  <= ~load_tgl;
      end else if (busy) begin
         shreg     <= {shreg[WORD_W-2:0], 1'b0};
         bits_left <= bits_left - 1'b1;
         if (bits_left == CNT_W'(1)) busy <= 1'b0;
      end
   end

   // Rising edge: launch the current MSB
   always_ff @(posedge bclk or negedge rst_n) begin
      if (!rst_n) sd <= 1'b0;
      else        sd <= busy & shreg[WORD_W-1];
   end

   // R3: a frame always loads a legal length
   a_r3_load_len : assert property (@(negedge bclk) disable iff (!rst_n)
      fsync |=> (bits_left == CNT_W'(WORD_W) || bits_left == CNT_W'(BYTE_W)));
   // R3: while busy the counter stays within a word
   a_r3_cnt_range : assert property (@(negedge bclk) disable iff (!rst_n)
      busy |-> (bits_left != '0 && bits_left <= CNT_W'(WORD_W)));
   // R4: the line idles low
   a_r4_idle_low : assert property (@(posedge bclk) disable iff (!rst_n)
      !busy |=> !sd);
endmodule

// File: rtl/sport_rx_lane.sv
// Receive shift path, clocked entirely by the external receive bit clock.
module sport_rx_lane #(
   parameter int WORD_W = 16,
   parameter int BYTE_W = 8
) (
   input  logic              bclk,
   input  logic              rst_n,
   input  logic              fsync,
   input  logic              sd,
   input  logic              word_mode,
   output logic [WORD_W-1:0] word_out,
   output logic              done_tgl
);
   localparam int CNT_W = $clog2(WORD_W + 1);
   localparam int PAD_W = WORD_W - BYTE_W;

   generate
      if (BYTE_W < 2 || PAD_W < 1) begin : g_bad_widths
         $error("sport_rx_lane: need 2 <= BYTE_W < WORD_W");
      end
   endgenerate

   // The final bit is taken straight from the pin, so one less stored bit is needed.
   logic [WORD_W-2:0] shreg;
   logic [CNT_W-1:0]  bits_left;
   logic              busy;
   logic [WORD_W-1:0] full_word;

   always_comb begin
      if (word_mode) full_word = {shreg, sd};
      else           full_word = {{PAD_W{1'b0}}, shreg[BYTE_W-2:0], sd};
   end

   always_ff @(negedge bclk or negedge rst_n) begin
      if (!rst_n) begin
         shreg     <= '0;
         bits_left <= '0;
         busy      <= 1'b0;
         word_out  <= '0;
         done_tgl  <= 1'b0;
      end else begin
         if (busy) begin
            shreg     <= {shreg[WORD_W-3:0], sd};
            bits_left <= bits_left - 1'b1;
            if (bits_left == CNT_W'(1)) begin
               busy     <= 1'b0;
               word_out <= full_word;
               done_tgl <= ~done_tgl;
            end
         end
         // A sync on the last bit edge restarts at once (no idle bit)
         if (fsync) begin
            busy      <= 1'b1;
            bits_left <= word_mode ? CNT_W'(WORD_W) : CNT_W'(BYTE_W);
         end
      end
   end

   // R6: the counter stays within a word while a frame is open
   a_r6_cnt_range : assert property (@(negedge bclk) disable iff (!rst_n)
      busy |-> (bits_left != '0 && bits_left <= CNT_W'(WORD_W)));
   // R7: a byte-mode completion leaves the upper bits clear
   a_r7_upper_zero : assert property (@(negedge bclk) disable iff (!rst_n)
      (busy && bits_left == CNT_W'(1) && !word_mode && !fsync)
         |=> (word_out[WORD_W-1:BYTE_W] == '0));
endmodule

// File: rtl/sport_duplex.sv
module sport_duplex
   import sport_pkg::*;
#(
   parameter int WORD_W      = 16,
   parameter int BYTE_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [SP_ADDR_W-1:0] wr_addr,
   input  logic [WORD_W-1:0]    wr_data,
   input  logic [SP_ADDR_W-1:0] rd_addr,
   output logic [WORD_W-1:0]    rd_data,
   input  logic                 tx_bclk,
   input  logic                 tx_fsync,
   output logic                 tx_sd,
   input  logic                 rx_bclk,
   input  logic                 rx_fsync,
   input  logic                 rx_sd,
   output logic                 irq_tx_empty,
   output logic                 irq_rx_full
);
   generate
      if (WORD_W <= BYTE_W) begin : g_bad_word
         $error("sport_duplex: WORD_W must exceed BYTE_W");
      end
   endgenerate

   logic [WORD_W-1:0] tx_hold;
   logic [WORD_W-1:0] rx_data_q;
   logic [WORD_W-1:0] rx_word_b;
   logic              word_mode;
   logic              tx_tgl, rx_tgl;
   logic              tx_pulse, rx_pulse;

   // System-domain registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_hold   <= '0;
         word_mode <= 1'b1;
      end else if (wr_en) begin
         if (wr_addr == SP_REG_TX)  tx_hold   <= wr_data;
         if (wr_addr == SP_REG_CTL) word_mode <= wr_data[0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_data_q    <= '0;
         irq_tx_empty <= 1'b0;
         irq_rx_full  <= 1'b0;
      end else begin
         irq_tx_empty <= tx_pulse;
         irq_rx_full  <= rx_pulse;
         if (rx_pulse) rx_data_q <= rx_word_b;
      end
   end

   always_comb begin
      case (sp_reg_e'(rd_addr))
         SP_REG_TX:  rd_data = tx_hold;
         SP_REG_RX:  rd_data = rx_data_q;
         SP_REG_CTL: rd_data = {{(WORD_W-1){1'b0}}, word_mode};
         default:    rd_data = '0;
      endcase
   end

   sport_tx_lane #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) tx_lane_i (
      .bclk(tx_bclk), .rst_n(rst_n), .fsync(tx_fsync), .word_mode(word_mode),
      .hold_word(tx_hold), .sd(tx_sd), .load_tgl(tx_tgl));

   sport_rx_lane #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) rx_lane_i (
      .bclk(rx_bclk), .rst_n(rst_n), .fsync(rx_fsync), .sd(rx_sd),
      .word_mode(word_mode), .word_out(rx_word_b), .done_tgl(rx_tgl));

   sport_tgl_sync #(.STAGES(SYNC_STAGES)) tx_sync_i (
      .clk(clk), .rst_n(rst_n), .tgl_in(tx_tgl), .pulse(tx_pulse));

   sport_tgl_sync #(.STAGES(SYNC_STAGES)) rx_sync_i (
      .clk(clk), .rst_n(rst_n), .tgl_in(rx_tgl), .pulse(rx_pulse));

   // R5: transmit interrupt is a single-cycle pulse
   a_r5_tx_irq_single : assert property (@(posedge clk) disable iff (!rst_n)
      irq_tx_empty |=> !irq_tx_empty);
   // R6: receive interrupt is a single-cycle pulse
   a_r6_rx_irq_single : assert property (@(posedge clk) disable iff (!rst_n)
      irq_rx_full |=> !irq_rx_full);
   // R10: the receive register only moves on a completion
   a_r10_rx_hold : assert property (@(posedge clk) disable iff (!rst_n)
      !rx_pulse |=> $stable(rx_data_q));
endmodule

// File: tb/sport_duplex_tb_top.sv
`timescale 1ns/1ps
module sport_duplex_tb_top;
   logic        clk = 0, rst_n = 0;
   logic        wr_en = 0;
   logic [1:0]  wr_addr = 0, rd_addr = 0;
   logic [15:0] wr_data = 0;
   logic [15:0] rd_data;
   logic        tx_bclk = 0, tx_fsync = 0, tx_sd;
   logic        rx_bclk = 0, rx_fsync = 0, rx_sd = 0;
   logic        irq_tx_empty, irq_rx_full;

   int errors = 0, checks = 0;
   int tx_irq_n = 0, rx_irq_n = 0;
   int tx_loads = 0, rx_done = 0;
   int tx_nbits = 16;
   string tx_tag = "R3", rx_tag = "R6";
   logic [15:0] tx_q[$], rx_q[$];
   logic [15:0] tx_words [0:3];
   logic [15:0] rx_words [0:3];
   logic [15:0] tx_acc = 0;
   int tx_cnt = 0;
   logic [15:0] last_rx = 0;

   always #2.5 clk = ~clk;
   always #20 tx_bclk = ~tx_bclk;
   always #28 rx_bclk = ~rx_bclk;

   sport_duplex #(.WORD_W(16), .BYTE_W(8), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .tx_bclk(tx_bclk), .tx_fsync(tx_fsync),
      .tx_sd(tx_sd), .rx_bclk(rx_bclk), .rx_fsync(rx_fsync), .rx_sd(rx_sd),
      .irq_tx_empty(irq_tx_empty), .irq_rx_full(irq_rx_full));

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
      @(negedge clk); wr_en = 0;
   endtask

   task automatic rd_chk(input string req, input logic [1:0] a, input logic [15:0] exp);
      @(negedge clk); rd_addr = a;
      #1 chk(req, rd_data, exp);
   endtask

   task automatic summary;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   // Interrupt counters, sampled away from the system edge
   always @(negedge clk) begin
      if (rst_n && irq_tx_empty) tx_irq_n++;
      if (rst_n && irq_rx_full) begin
         rx_irq_n++;
         if (rx_q.size() == 0) chk({rx_tag, " unexpected rx word"}, rd_data, 16'hxxxx);
         else begin
            last_rx = rx_q.pop_front();
            chk(rx_tag, rd_data, last_rx);
         end
      end
   end

   // Transmit monitor: collects bits on falling edges after a frame sync
   always @(negedge tx_bclk) begin
      if (tx_cnt > 0) begin
         tx_acc = {tx_acc[14:0], tx_sd};
         tx_cnt--;
         if (tx_cnt == 0) begin
            if (tx_q.size() == 0) chk({tx_tag, " unexpected tx word"}, tx_acc, 16'hxxxx);
            else chk(tx_tag, tx_acc, tx_q.pop_front());
         end
      end
      if (tx_fsync) begin
         tx_cnt = tx_nbits;
         tx_acc = 0;
      end
   end

   // Transmit driver: pushes expected words, rewrites the register mid-frame
   task automatic tx_run(input int nf, input bit chain);
      int n = tx_nbits;
      wr(2'd0, tx_words[0]);
      @(posedge tx_bclk); #1 tx_fsync = 1;
      for (int f = 0; f < nf; f++) begin
         tx_q.push_back(n == 16 ? tx_words[f] : {8'h00, tx_words[f][7:0]});
         tx_loads++;
         for (int k = 1; k <= n; k++) begin
            @(posedge tx_bclk); #1;
            if (k == 1) tx_fsync = 0;
            if (k == 2 && f + 1 < nf) wr(2'd0, tx_words[f+1]);
            if (k == n && chain && f + 1 < nf) tx_fsync = 1;
         end
         if (!chain && f + 1 < nf) begin
            repeat (2) @(posedge tx_bclk);
            #1 tx_fsync = 1;
         end
      end
   endtask

   // Receive driver: bits change just after rising edges
   task automatic rx_run(input int nf, input bit chain, input int n);
      @(posedge rx_bclk); #1 rx_fsync = 1;
      for (int f = 0; f < nf; f++) begin
         rx_q.push_back(n == 16 ? rx_words[f] : {8'h00, rx_words[f][7:0]});
         rx_done++;
         for (int k = 1; k <= n; k++) begin
            @(posedge rx_bclk); #1;
            rx_sd = rx_words[f][n-k];
            if (k == 1) rx_fsync = 0;
            if (k == n && chain && f + 1 < nf) rx_fsync = 1;
         end
         if (!chain && f + 1 < nf) begin
            @(posedge rx_bclk); #1 rx_sd = 0;
            @(posedge rx_bclk); #1 rx_fsync = 1;
         end
      end
      @(posedge rx_bclk); #1 rx_sd = 0;
   endtask

   initial begin
      #900000;
      errors++; checks++;
      $display("FAIL R9 watchdog actual=timeout expected=completion");
      summary();
   end

   initial begin
      #100 rst_n = 1;
      // R1: reset state
      rd_chk("R1 tx reg", 2'd0, 16'h0000);
      rd_chk("R1 rx reg", 2'd1, 16'h0000);
      rd_chk("R1 ctl reg", 2'd2, 16'h0001);
      chk("R1 tx_sd", {15'd0, tx_sd}, 16'h0);
      chk("R1 irqs", {14'd0, irq_tx_empty, irq_rx_full}, 16'h0);

      // R2: register write and readback
      wr(2'd0, 16'hA5C3); rd_chk("R2 tx readback", 2'd0, 16'hA5C3);
      wr(2'd2, 16'h0000); rd_chk("R2 ctl byte", 2'd2, 16'h0000);
      wr(2'd2, 16'hFFFF); rd_chk("R2 ctl word", 2'd2, 16'h0001);
      rd_addr = 2'd1;

      // R3, R5, R8: word mode, chained frames, register rewritten mid-frame
      tx_nbits = 16; tx_tag = "R3/R5/R8 tx word";
      tx_words[0] = 16'h1234; tx_words[1] = 16'hBEEF; tx_words[2] = 16'h8001;
      tx_run(3, 1'b1);
      repeat (3) @(negedge tx_bclk);
      chk("R4 idle low after word", {15'd0, tx_sd}, 16'h0);

      // R4: byte mode, gapped frames
      wr(2'd2, 16'h0000);
      tx_nbits = 8; tx_tag = "R4 tx byte";
      tx_words[0] = 16'h12A7; tx_words[1] = 16'hFF3C;
      tx_run(2, 1'b0);
      repeat (3) @(negedge tx_bclk);
      chk("R4 idle low after byte", {15'd0, tx_sd}, 16'h0);

      // R7, R8: byte receive, chained
      rx_tag = "R7/R8 rx byte";
      rx_words[0] = 16'hAB5A; rx_words[1] = 16'h0081;
      rx_run(2, 1'b1, 8);
      repeat (20) @(negedge clk);

      // R6: single word receive
      wr(2'd2, 16'h0001);
      rx_tag = "R6 rx word";
      rx_words[0] = 16'h5A5A;
      rx_run(1, 1'b0, 16);
      repeat (20) @(negedge clk);

      // R9: full duplex on unrelated clocks
      tx_nbits = 16; tx_tag = "R9 tx duplex";
      rx_tag = "R9 rx duplex";
      tx_words[0] = 16'hC0DE; tx_words[1] = 16'h7E57;
      rx_words[0] = 16'h9A3F; rx_words[1] = 16'h0F0F; rx_words[2] = 16'h8000;
      fork
         tx_run(2, 1'b1);
         rx_run(3, 1'b1, 16);
      join
      repeat (40) @(negedge clk);

      // R10: receive register holds its value
      chk("R10 rx hold", rd_data, 16'h8000);
      repeat (50) @(negedge clk);
      #1 chk("R10 rx hold later", rd_data, 16'h8000);

      chk("R5 tx irq count", 16'(tx_irq_n), 16'(tx_loads));
      chk("R6 rx irq count", 16'(rx_irq_n), 16'(rx_done));
      chk("R5 tx queue drained", 16'(tx_q.size()), 16'h0);
      summary();
   end
endmodule